// File: doc/BRIEF.md
# Interrupt Cause Register with Moderation

This block collects interrupt causes into a 32-bit cause register, filters them through a mask register, and drives one level-sensitive interrupt line towards a host. Internal event sources raise causes with single-cycle set pulses. The host changes the cause register with set and clear writes, and the mask register the same way. A host read of the cause register returns its contents and clears it.

A moderation timer limits how often the line can rise. When the line is low and pending causes appear, the block picks a delay. The candidates are a general throttle value, a transmit absolute delay and a receive absolute delay. The line stays low until that delay has run out, and is then set again from the pending causes at that moment. One delay unit is `UNIT_CYC` clock cycles. Register writes and reads are single-cycle strobes with no back-pressure: every strobe takes effect at the next clock edge.

Top module: `irq_moderator`

## Requirements
- R1: A cause-set write (address 0) ORs the written data into the cause register. Bits on `ev_set` are ORed in at the same edge. `rd_data` always shows the cause register.
- R2: A cause-clear write (address 1) removes the written bits from the cause register. An `ev_set` bit raised on the same edge survives the clear.
- R3: A mask-set write (address 2) ORs the data into the mask. A mask-clear write (address 3) removes the written bits from the mask.
- R4: The pending vector is the mask ANDed with the cause register. With no moderation delay in effect, `irq` equals "pending is nonzero", updated at the same edge as the register change that causes it.
- R5: A strobe on `rd_cause` clears the cause register at the next edge, and `irq` falls at that edge. Event bits on `ev_set` in the same cycle are kept.
- R6: The throttle value (address 4, low 16 bits of the data, upper bits ignored) is always a delay candidate. When pending appears at edge t while the line is low and the timer is idle, and the chosen delay D is nonzero, `irq` rises at edge t + D·UNIT_CYC.
- R7: The candidate 4 × transmit delay (address 5) applies only if two conditions hold: the transmit delay-enable flag is set, and a transmit cause (bit 0 or bit 1) is pending. Among the nonzero candidates the smallest is used. If every candidate is zero, `irq` rises at once.
- R8: The candidate 4 × receive delay (address 6) applies only if two conditions hold: the receive timer value (address 7) is nonzero, and the receive-timer cause (bit 7) is pending.
- R9: While the timer runs and the line is low, newly pending bits keep the line low. At expiry the line is set to "pending is nonzero". If the causes were cleared in the meantime, the line stays low.
- R10: A `txd_ide` pulse sets the transmit delay-enable flag. Starting the timer clears the flag, so the next moderation decision ignores the transmit candidate.
- R11: Reset clears the cause, mask and delay registers, the timer, the line and the delay-enable flag.
- R12: When the line is high and pending becomes zero (from a cause clear or a mask clear), the line falls at that same edge without waiting for any timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_set | input | 32 | Cause-set pulses from event sources |
| txd_ide | input | 1 | Transmit descriptor carried the delay-enable command |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write target: 0 cause set, 1 cause clear, 2 mask set, 3 mask clear, 4 throttle, 5 tx delay, 6 rx delay, 7 rx timer |
| wr_data | input | 32 | Write data |
| rd_cause | input | 1 | Read-and-clear strobe for the cause register |
| rd_data | output | 32 | Current cause register |
| irq | output | 1 | Level interrupt line |

## Verification
The unmoderated path is swept over every cause bit against an alternating mask pattern, which separates the set, clear and masking decisions bit by bit. The moderated path is swept over every combination of throttle, transmit delay, receive delay, receive timer value, delay-enable flag and cause pattern (transmit, receive, both, neither). Measuring the exact rise cycle tells apart which candidate won, the smallest-nonzero rule, and the immediate case. Directed sequences add pending bits during a running timer, clear causes before expiry, reuse a consumed delay-enable flag, and race events against clears and reads.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  typedef enum logic [2:0] {
    REG_CSET  = 3'd0,
    REG_CCLR  = 3'd1,
    REG_MSET  = 3'd2,
    REG_MCLR  = 3'd3,
    REG_THROT = 3'd4,
    REG_TXDLY = 3'd5,
    REG_RXDLY = 3'd6,
    REG_RXTMR = 3'd7
  } irqm_reg_e;

  localparam int N_CAND = 3;
endpackage

// File: rtl/irqm_regs.sv
module irqm_regs
  import irqm_pkg::*;
#(
  parameter int CAUSE_W = 32,
  parameter int DLY_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] ev_set,
  input  logic               wr_en,
  input  irqm_reg_e          wr_sel,
  input  logic [31:0]        wr_data,
  input  logic               rd_clr,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [CAUSE_W-1:0] mask_q,
  output logic [CAUSE_W-1:0] cause_nxt,
  output logic [CAUSE_W-1:0] mask_nxt,
  output logic [DLY_W-1:0]   thr_q,
  output logic [DLY_W-1:0]   txdly_q,
  output logic [DLY_W-1:0]   rxdly_q,
  output logic [DLY_W-1:0]   rxtmr_q
);
  logic [CAUSE_W-1:0] wdat;
  assign wdat = wr_data[CAUSE_W-1:0];

  always_comb begin
    cause_nxt = rd_clr ? '0 : cause_q;
    mask_nxt  = mask_q;
    if (wr_en) begin
      case (wr_sel)
        REG_CSET: cause_nxt = cause_nxt | wdat;
        REG_CCLR: cause_nxt = cause_nxt & ~wdat;
        REG_MSET: mask_nxt  = mask_q | wdat;
        REG_MCLR: mask_nxt  = mask_q & ~wdat;
        default:  ;
      endcase
    end
    cause_nxt = cause_nxt | ev_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
      thr_q   <= '0;
      txdly_q <= '0;
      rxdly_q <= '0;
      rxtmr_q <= '0;
    end else begin
      cause_q <= cause_nxt;
      mask_q  <= mask_nxt;
      if (wr_en) begin
        case (wr_sel)
          REG_THROT: thr_q   <= wr_data[DLY_W-1:0];
          REG_TXDLY: txdly_q <= wr_data[DLY_W-1:0];
          REG_RXDLY: rxdly_q <= wr_data[DLY_W-1:0];
          REG_RXTMR: rxtmr_q <= wr_data[DLY_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  // R2: cleared bits are gone unless an event re-raised them
  a_r2_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == REG_CCLR && ev_set == '0)
      |=> ((cause_q & $past(wdat)) == '0));

  // R3: mask-set bits are present afterwards
  a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == REG_MSET) |=> ((mask_q & $past(wdat)) == $past(wdat)));

  // R5: read-and-clear with no concurrent source empties the register
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !wr_en && ev_set == '0) |=> (cause_q == '0));
endmodule

// File: rtl/irqm_delay_sel.sv
module irqm_delay_sel
  import irqm_pkg::*;
#(
  parameter int W = 18
) (
  input  logic [N_CAND-1:0][W-1:0] cand,
  output logic [W-1:0]             pick
);
  logic [N_CAND-1:0] nz;

  for (genvar gi = 0; gi < N_CAND; gi++) begin : g_nz
    assign nz[gi] = |cand[gi];
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < N_CAND; i++) begin
      if (nz[i] && (pick == '0 || cand[i] < pick)) pick = cand[i];
    end
  end
endmodule

// File: rtl/irqm_timer.sv
module irqm_timer #(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = running && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt_q   <= load;
    end else if (running) begin
      if (expire) running <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R9: a running countdown is never restarted
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running);

  // R6: the timer keeps running until its count reaches the end
  a_r6_runs_to_end: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !expire) |=> running);
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irqm_pkg::*;
#(
  parameter int          CAUSE_W  = 32,
  parameter int          DLY_W    = 16,
  parameter int          UNIT_CYC = 256,
  parameter logic [31:0] TX_MASK  = 32'h0000_0003,
  parameter int          RX_BIT   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] ev_set,
  input  logic               txd_ide,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               rd_cause,
  output logic [CAUSE_W-1:0] rd_data,
  output logic               irq
);
  localparam int CW    = DLY_W + 2;
  localparam int CNT_W = CW + $clog2(UNIT_CYC + 1);

  logic [CAUSE_W-1:0] cause_q, mask_q, cause_nxt, mask_nxt, pend_nxt;
  logic [DLY_W-1:0]   thr_q, txdly_q, rxdly_q, rxtmr_q;
  logic [N_CAND-1:0][CW-1:0] cand;
  logic [CW-1:0]      pick;
  logic [CNT_W-1:0]   load;
  logic               tm_run, tm_exp, tm_start;
  logic               irq_q, irq_d, ide_q, any_nxt;

  irqm_regs #(.CAUSE_W(CAUSE_W), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .wr_en(wr_en),
    .wr_sel(irqm_reg_e'(wr_addr)), .wr_data(wr_data), .rd_clr(rd_cause),
    .cause_q(cause_q), .mask_q(mask_q), .cause_nxt(cause_nxt),
    .mask_nxt(mask_nxt), .thr_q(thr_q), .txdly_q(txdly_q),
    .rxdly_q(rxdly_q), .rxtmr_q(rxtmr_q)
  );

  assign pend_nxt = cause_nxt & mask_nxt;
  assign any_nxt  = |pend_nxt;

  assign cand[0] = {2'b00, thr_q};
  assign cand[1] = (ide_q && |(pend_nxt & TX_MASK[CAUSE_W-1:0]))
                   ? {txdly_q, 2'b00} : '0;
  assign cand[2] = ((|rxtmr_q) && pend_nxt[RX_BIT]) ? {rxdly_q, 2'b00} : '0;

  irqm_delay_sel #(.W(CW)) u_sel (.cand(cand), .pick(pick));

  assign load = CNT_W'(pick) * CNT_W'(UNIT_CYC);

  always_comb begin
    tm_start = 1'b0;
    irq_d    = any_nxt;
    if (tm_exp) begin
      irq_d = any_nxt;
    end else if (!irq_q && any_nxt) begin
      if (tm_run) begin
        irq_d = 1'b0;
      end else if (pick != '0) begin
        tm_start = 1'b1;
        irq_d    = 1'b0;
      end else begin
        irq_d = 1'b1;
      end
    end
  end

  irqm_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tm_start), .load(load),
    .running(tm_run), .expire(tm_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      ide_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      ide_q <= (tm_start ? 1'b0 : ide_q) | txd_ide;
    end
  end

  assign irq     = irq_q;
  assign rd_data = cause_q;

  // R4: the line is only high while something is pending
  a_r4_line_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (|(cause_q & mask_q)));

  // R9: the line never rises while the countdown is still running
  a_r9_rise_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> !tm_run);

  // R10: starting the countdown consumes the delay-enable flag
  a_r10_start_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_start && !txd_ide) |=> !ide_q);
endmodule

// File: tb/irq_moderator_tb.sv
module irq_moderator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int U = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ev_set = '0;
  logic        txd_ide = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_cause = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_moderator #(.UNIT_CYC(U)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .txd_ide(txd_ide),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_cause(rd_cause), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ev_set = '0; txd_ide = 1'b0; wr_en = 1'b0; rd_cause = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ide_pulse();
    txd_ide = 1'b1;
    @(negedge clk);
    txd_ide = 1'b0;
  endtask

  // cycles from the triggering edge until irq is seen high
  task automatic rise_time(output int k);
    k = 0;
    while (irq !== 1'b1 && k < 300) begin
      @(negedge clk);
      k++;
    end
  endtask

  function automatic int exp_delay(int thr, int td, int rd, int rt, bit ide, logic [31:0] pat);
    int c[3];
    int best;
    c[0] = thr;
    c[1] = (ide && (pat & 32'h3) != 0) ? td * 4 : 0;
    c[2] = (rt != 0 && pat[7]) ? rd * 4 : 0;
    best = 0;
    for (int i = 0; i < 3; i++)
      if (c[i] != 0 && (best == 0 || c[i] < best)) best = c[i];
    return best;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int k;
    logic [31:0] pats[4];
    pats[0] = 32'h0000_0001; pats[1] = 32'h0000_0080;
    pats[2] = 32'h0000_0081; pats[3] = 32'h0000_0010;

    // R11: reset state
    do_reset();
    check("R11 irq after reset", {31'b0, irq}, 32'h0);
    check("R11 cause after reset", rd_data, 32'h0);

    // R1 R2 R4: per-bit sweep without moderation
    wr(3'd2, 32'h5555_5555);
    for (int i = 0; i < 32; i++) begin
      wr(3'd0, 32'h1 << i);
      check("R1 cause set", rd_data, 32'h1 << i);
      check("R4 line equals pending", {31'b0, irq}, {31'b0, (i % 2 == 0)});
      wr(3'd1, 32'h1 << i);
      check("R2 cause clear", rd_data, 32'h0);
      check("R4 line after clear", {31'b0, irq}, 32'h0);
    end

    // R1: events OR in, writes OR on top
    ev_set = 32'h300; @(negedge clk); ev_set = '0;
    check("R1 event sets", rd_data, 32'h300);
    wr(3'd0, 32'h1);
    check("R1 write ORs", rd_data, 32'h301);
    // R2: event wins over a clear on the same edge
    ev_set = 32'h8; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'hFFFF_FFFF;
    @(negedge clk); ev_set = '0; wr_en = 1'b0;
    check("R2 event survives clear", rd_data, 32'h8);

    // R3 R12: mask set/clear
    do_reset();
    wr(3'd2, 32'hFF); wr(3'd3, 32'hFF);
    wr(3'd0, 32'h1);
    check("R3 mask clear blocks", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h1);
    check("R3 mask set raises line", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'h1);
    check("R12 mask clear drops line", {31'b0, irq}, 32'h0);

    // R5: read-and-clear
    do_reset();
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd0, 32'h81);
    check("R5 value before read", rd_data, 32'h81);
    rd_cause = 1'b1; @(negedge clk); rd_cause = 1'b0;
    check("R5 cleared by read", rd_data, 32'h0);
    check("R5 line drops on read", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h2);
    rd_cause = 1'b1; ev_set = 32'h10; @(negedge clk); rd_cause = 1'b0; ev_set = '0;
    check("R5 event kept across read", rd_data, 32'h10);
    check("R5 line from kept event", {31'b0, irq}, 32'h1);

    // R11: reset clears mask and delays
    do_reset();
    wr(3'd0, 32'h4);
    check("R11 mask cleared by reset", {31'b0, irq}, 32'h0);
    wr(3'd4, 32'h5);
    do_reset();
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd0, 32'h4);
    check("R11 throttle cleared by reset", {31'b0, irq}, 32'h1);

    // R6: upper throttle bits ignored
    do_reset();
    wr(3'd4, 32'h0001_0002); wr(3'd2, 32'hFFFF_FFFF); wr(3'd0, 32'h4);
    rise_time(k);
    check("R6 throttle low bits only", k, 2 * U);

    // R6 R7 R8: sweep of all candidate combinations
    foreach (pats[p]) begin
      for (int thr = 0; thr < 3; thr++)
        for (int td = 0; td < 3; td++)
          for (int rd = 0; rd < 2; rd++)
            for (int rt = 0; rt < 2; rt++)
              for (int ide = 0; ide < 2; ide++) begin
                int tv, tdv;
                tv = (thr == 2) ? 5 : thr * 2;
                tdv = (td == 2) ? 3 : td;
                do_reset();
                wr(3'd4, tv); wr(3'd5, tdv); wr(3'd6, rd); wr(3'd7, rt);
                if (ide != 0) ide_pulse();
                wr(3'd2, 32'hFFFF_FFFF);
                wr(3'd0, pats[p]);
                rise_time(k);
                check("R6 R7 R8 delay choice", k,
                      exp_delay(tv, tdv, rd, rt, ide != 0, pats[p]) * U);
              end
    end

    // R9: new pending during countdown stays low until expiry
    do_reset();
    wr(3'd4, 32'h4); wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd0, 32'h4);
    check("R9 held low at start", {31'b0, irq}, 32'h0);
    repeat (5) @(negedge clk);
    wr(3'd0, 32'h8);
    repeat (5) @(negedge clk);
    check("R9 still low before expiry", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 high at expiry", {31'b0, irq}, 32'h1);
    // R12: clearing the cause with the line high drops it at once
    wr(3'd1, 32'hFFFF_FFFF);
    check("R12 clear drops line", {31'b0, irq}, 32'h0);

    // R9: cause cleared before expiry keeps the line low
    do_reset();
    wr(3'd4, 32'h2); wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd0, 32'h4); wr(3'd1, 32'h4);
    repeat (10) @(negedge clk);
    check("R9 low after expiry with nothing pending", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h2);
    rise_time(k);
    check("R9 fresh countdown after idle", k, 2 * U);

    // R10: flag is consumed by the first countdown
    do_reset();
    wr(3'd5, 32'h1); ide_pulse(); wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd0, 32'h1);
    rise_time(k);
    check("R10 tx delay used", k, 4 * U);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 32'h1);
    check("R10 flag consumed, immediate", {31'b0, irq}, 32'h1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule